// File: doc/BRIEF.md
# Burst Read Wait-State Generator

This block is the read side of a synchronous burst memory. When chip enable is high, an address-valid strobe captures a start address. After a fixed initial latency the block delivers one word per clock from an internal word array, at consecutive addresses. A ready flag marks every clock that carries a valid word. The flag stays low during the initial latency and during any stall.

Words are grouped into aligned blocks of 16. The first time a continuous burst steps from the last word of one block into the next block, the block inserts stall cycles. The number of stall cycles equals the two lowest bits of the start address. Later block crossings in the same burst cost nothing. Dropping chip enable ends the burst at once. A fresh strobe in the middle of a burst starts over, with full latency, and re-arms the first-crossing stall.

Top module: `burst_wait_gen`

## Requirements
- R1: An address-valid strobe has no effect while chip enable is low: ready stays low and no burst starts.
- R2: On a clock edge where chip enable and the strobe are both high, the address is captured. Ready is low during the INIT_LAT (default 5) clocks after that edge. The first word appears in the next clock.
- R3: In a burst, every ready-high clock delivers the word at the current address. The next address is one higher. The word at address a equals ((a mod 64) * 40503 + 23130) mod 65536.
- R4: A block crossing is a step from an address whose low four bits are 1111 to the next address. At the first block crossing of a burst, ready is low for exactly s clocks, where s is the start address mod 4. If s is 0, for example a start address that is a multiple of 16, there is no stall.
- R5: The second and any later block crossings in one continuous burst insert no stall clocks.
- R6: The address does not advance during latency or stall clocks. The first word after a stall is the word that follows the last word delivered.
- R7: While ready is low, the data output is zero.
- R8: If chip enable is low at a clock edge, ready is low after that edge. Ready then stays low until a new strobe is captured.
- R9: A strobe captured during a burst restarts the sequence. It brings full initial latency, a new start address and a re-armed first-crossing stall.
- R10: The address counter wraps from its all-ones value to zero. That step counts as a block crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chip_en | input | 1 | Chip enable, active high |
| addr_strobe | input | 1 | Address-valid strobe, active high |
| addr_in | input | ADDR_W (24) | Start address of a burst |
| ready | output | 1 | High on clocks that carry a valid word |
| data_out | output | DATA_W (16) | Word being delivered; zero while ready is low |

## Verification
Some properties are checked by assertions on every clock:
- data stays zero while ready is low;
- ready is low after a capture edge and whenever chip enable is low;
- the address steps by one after each delivered word and holds otherwise;
- no run of stall clocks inside a streaming burst is longer than three.

Other behaviour can only be shown by the bench scenarios. These cover the exact stall count for each start-address residue, the absence of stalls at the second crossing, the restart semantics, the wrap through address zero and the data values themselves. A behavioural model predicts ready and data on every clock for all of these.

// File: rtl/burst_wait_pkg.sv
package burst_wait_pkg;

   // Phase of the read sequencer
   typedef enum logic [1:0] {
      BW_IDLE   = 2'd0,
      BW_LAT    = 2'd1,
      BW_STREAM = 2'd2,
      BW_STALL  = 2'd3
   } bw_phase_e;

   // Number of start-address bits that select the first-crossing stall
   localparam int BW_STALL_BITS = 2;

   // Constants of the word pattern held in the array
   localparam int BW_WORD_MUL = 40503;
   localparam int BW_WORD_ADD = 23130;

endpackage

// File: rtl/bw_addr_ctr.sv
module bw_addr_ctr #(
   parameter int ADDR_W     = 24,
   parameter int BOUND_LOG2 = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              advance,
   output logic [ADDR_W-1:0] addr,
   output logic              at_block_end
);

   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

   logic [ADDR_W-1:0] addr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q <= '0;
      end else if (load) begin
         addr_q <= load_addr;
      end else if (advance) begin
         addr_q <= addr_q + STEP;   // wraps naturally at all-ones
      end
   end

   assign addr         = addr_q;
   assign at_block_end = &addr_q[BOUND_LOG2-1:0];

endmodule

// File: rtl/bw_word_rom.sv
module bw_word_rom
   import burst_wait_pkg::*;
#(
   parameter int DATA_W    = 16,
   parameter int ROM_AW    = 6,
   parameter int ROM_STYLE = 0   // 0: stored table, 1: computed on the fly
) (
   input  logic [ROM_AW-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_word
);

   localparam int ROM_WORDS = 1 << ROM_AW;

   generate
      if (ROM_STYLE == 0) begin : g_table
         logic [DATA_W-1:0] table_q [ROM_WORDS];
         for (genvar gi = 0; gi < ROM_WORDS; gi++) begin : g_fill
            assign table_q[gi] = DATA_W'(gi * BW_WORD_MUL + BW_WORD_ADD);
         end
         assign rd_word = table_q[rd_addr];
      end else begin : g_calc
         logic [31:0] idx32;
         assign idx32   = 32'(rd_addr);
         assign rd_word = DATA_W'(idx32 * 32'(BW_WORD_MUL) + 32'(BW_WORD_ADD));
      end
   endgenerate

endmodule

// File: rtl/bw_wait_seq.sv
module bw_wait_seq
   import burst_wait_pkg::*;
#(
   parameter int INIT_LAT = 5
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     chip_en,
   input  logic                     addr_strobe,
   input  logic [BW_STALL_BITS-1:0] start_lsb,
   input  logic                     at_block_end,
   output logic                     load,
   output logic                     advance,
   output logic                     ready
);

   localparam int LAT_BITS = $clog2(INIT_LAT);
   localparam int CNT_W    = (LAT_BITS > BW_STALL_BITS) ? LAT_BITS : BW_STALL_BITS;
   localparam logic [CNT_W-1:0] LAT_LOAD = CNT_W'(INIT_LAT - 1);
   localparam logic [CNT_W-1:0] ONE      = CNT_W'(1);

   bw_phase_e              phase_q, phase_d;
   logic [CNT_W-1:0]       cnt_q, cnt_d;
   logic [BW_STALL_BITS-1:0] extra_q, extra_d;
   logic                   crossed_q, crossed_d;

   assign load    = chip_en & addr_strobe;
   assign advance = chip_en & ~addr_strobe & (phase_q == BW_STREAM);
   assign ready   = (phase_q == BW_STREAM);

   always_comb begin
      phase_d   = phase_q;
      cnt_d     = cnt_q;
      extra_d   = extra_q;
      crossed_d = crossed_q;
      if (!chip_en) begin
         phase_d   = BW_IDLE;
         cnt_d     = '0;
         crossed_d = 1'b0;
      end else if (addr_strobe) begin
         phase_d   = BW_LAT;
         cnt_d     = LAT_LOAD;
         extra_d   = start_lsb;
         crossed_d = 1'b0;
      end else begin
         unique case (phase_q)
            BW_IDLE: begin
               phase_d = BW_IDLE;
            end
            BW_LAT: begin
               if (cnt_q == '0) begin
                  phase_d = BW_STREAM;
               end else begin
                  cnt_d = cnt_q - ONE;
               end
            end
            BW_STREAM: begin
               if (at_block_end && !crossed_q) begin
                  crossed_d = 1'b1;
                  if (extra_q != '0) begin
                     phase_d = BW_STALL;
                     cnt_d   = CNT_W'(extra_q) - ONE;
                  end
               end
            end
            BW_STALL: begin
               if (cnt_q == '0) begin
                  phase_d = BW_STREAM;
               end else begin
                  cnt_d = cnt_q - ONE;
               end
            end
            default: phase_d = BW_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q   <= BW_IDLE;
         cnt_q     <= '0;
         extra_q   <= '0;
         crossed_q <= 1'b0;
      end else begin
         phase_q   <= phase_d;
         cnt_q     <= cnt_d;
         extra_q   <= extra_d;
         crossed_q <= crossed_d;
      end
   end

endmodule

// File: rtl/burst_wait_gen.sv
module burst_wait_gen
   import burst_wait_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int DATA_W     = 16,
   parameter int ROM_AW     = 6,
   parameter int BOUND_LOG2 = 4,
   parameter int INIT_LAT   = 5,
   parameter int ROM_STYLE  = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chip_en,
   input  logic              addr_strobe,
   input  logic [ADDR_W-1:0] addr_in,
   output logic              ready,
   output logic [DATA_W-1:0] data_out
);

   // Elaboration-time parameter checks
   generate
      if (INIT_LAT < 1) begin : g_bad_lat
         $error("burst_wait_gen: INIT_LAT must be at least 1");
      end
      if (BOUND_LOG2 < BW_STALL_BITS || BOUND_LOG2 > ADDR_W) begin : g_bad_bound
         $error("burst_wait_gen: BOUND_LOG2 out of range");
      end
      if (ROM_AW < 1 || ROM_AW > ADDR_W || ROM_AW > 12) begin : g_bad_rom
         $error("burst_wait_gen: ROM_AW out of range");
      end
      if (ROM_STYLE != 0 && ROM_STYLE != 1) begin : g_bad_style
         $error("burst_wait_gen: ROM_STYLE must be 0 or 1");
      end
   endgenerate

   logic              load;
   logic              advance;
   logic              ready_int;
   logic              at_block_end;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] rom_word;

   bw_wait_seq #(
      .INIT_LAT(INIT_LAT)
   ) u_seq (
      .clk          (clk),
      .rst_n        (rst_n),
      .chip_en      (chip_en),
      .addr_strobe  (addr_strobe),
      .start_lsb    (addr_in[BW_STALL_BITS-1:0]),
      .at_block_end (at_block_end),
      .load         (load),
      .advance      (advance),
      .ready        (ready_int)
   );

   bw_addr_ctr #(
      .ADDR_W    (ADDR_W),
      .BOUND_LOG2(BOUND_LOG2)
   ) u_addr (
      .clk          (clk),
      .rst_n        (rst_n),
      .load         (load),
      .load_addr    (addr_in),
      .advance      (advance),
      .addr         (addr_q),
      .at_block_end (at_block_end)
   );

   bw_word_rom #(
      .DATA_W   (DATA_W),
      .ROM_AW   (ROM_AW),
      .ROM_STYLE(ROM_STYLE)
   ) u_rom (
      .rd_addr (addr_q[ROM_AW-1:0]),
      .rd_word (rom_word)
   );

   assign ready    = ready_int;
   assign data_out = ready_int ? rom_word : '0;

endmodule

// File: rtl/bw_checker.sv
module bw_checker #(
   parameter int ADDR_W = 24,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              chip_en,
   input logic              addr_strobe,
   input logic              ready,
   input logic [DATA_W-1:0] data_out,
   input logic [ADDR_W-1:0] addr_q
);

   logic       seen_word;
   logic [2:0] gap_cnt;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         seen_word <= 1'b0;
         gap_cnt   <= '0;
      end else if (!chip_en || addr_strobe) begin
         seen_word <= 1'b0;
         gap_cnt   <= '0;
      end else if (ready) begin
         seen_word <= 1'b1;
         gap_cnt   <= '0;
      end else if (seen_word && gap_cnt != 3'd7) begin
         gap_cnt <= gap_cnt + 3'd1;
      end
   end

   AST_CAPTURE_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      (chip_en && addr_strobe) |=> !ready);                                   // R2
   AST_NOCE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !chip_en |=> !ready);                                                   // R8
   AST_DATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |-> (data_out == '0));                                           // R7
   AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && chip_en && !addr_strobe) |=> (addr_q == ($past(addr_q) + ADDR_W'(1)))); // R3
   AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ready && !(chip_en && addr_strobe)) |=> $stable(addr_q));             // R6
   AST_STALL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      gap_cnt <= 3'd3);                                                       // R4

endmodule

bind burst_wait_gen bw_checker #(
   .ADDR_W(ADDR_W),
   .DATA_W(DATA_W)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .chip_en     (chip_en),
   .addr_strobe (addr_strobe),
   .ready       (ready),
   .data_out    (data_out),
   .addr_q      (addr_q)
);

// File: tb/burst_wait_gen_test.sv
module burst_wait_gen_test;

   localparam int ADDR_W   = 24;
   localparam int DATA_W   = 16;
   localparam int INIT_LAT = 5;
   localparam int AMASK    = (1 << ADDR_W) - 1;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              chip_en = 1'b0;
   logic              addr_strobe = 1'b0;
   logic [ADDR_W-1:0] addr_in = '0;
   logic              ready;
   logic [DATA_W-1:0] data_out;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R3";

   burst_wait_gen uut (
      .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .addr_strobe(addr_strobe),
      .addr_in(addr_in), .ready(ready), .data_out(data_out)
   );

   always #5 clk = ~clk;

   function automatic int word_of(int a);
      return ((a % 64) * 40503 + 23130) % 65536;
   endfunction

   task automatic check(bit ok, string req, int act, int exp, string what);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Behavioural reference model
   bit m_act = 0;
   int m_wait = 0;
   int m_addr = 0;
   bit m_crossed = 0;
   int m_extra = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_act = 0; m_wait = 0; m_crossed = 0;
      end else if (!chip_en) begin
         m_act = 0; m_crossed = 0;
      end else if (addr_strobe) begin
         m_act = 1; m_wait = INIT_LAT; m_addr = int'(addr_in);
         m_crossed = 0; m_extra = int'(addr_in) % 4;
      end else if (m_act) begin
         if (m_wait > 0) m_wait--;
         else begin
            if ((m_addr % 16) == 15 && !m_crossed) begin
               m_crossed = 1;
               m_wait = m_extra;
            end
            m_addr = (m_addr + 1) & AMASK;
         end
      end
   end

   // Compare with the model on every clock
   always @(negedge clk) begin
      if (rst_n) begin
         bit exp_r;
         int exp_d;
         exp_r = m_act && (m_wait == 0);
         exp_d = exp_r ? word_of(m_addr) : 0;
         check(ready == exp_r, cur_tag, int'(ready), int'(exp_r), "ready vs model");
         check(int'(data_out) == exp_d, exp_r ? "R3" : "R7", int'(data_out), exp_d, "data vs model");
      end
   end

   int gaps[64];

   // Strobe address a and record the low clocks before each of n words
   task automatic burst(int a, int n);
      int low = 0;
      int k = 0;
      @(negedge clk);
      chip_en = 1'b1; addr_strobe = 1'b1; addr_in = ADDR_W'(a);
      @(negedge clk);
      addr_strobe = 1'b0;
      while (k < n) begin
         if (ready) begin
            gaps[k] = low; k++; low = 0;
         end else begin
            low++;
         end
         if (k < n) @(negedge clk);
      end
   endtask

   task automatic crossing_case(int a, string tag);
      int k1;
      k1 = 16 - (a % 16);
      cur_tag = tag;
      burst(a, k1 + 18);
      check(gaps[0] == INIT_LAT, "R2", gaps[0], INIT_LAT, "initial latency");
      check(gaps[k1] == a % 4, "R4", gaps[k1], a % 4, "first crossing stall");
      check(gaps[k1 + 16] == 0, "R5", gaps[k1 + 16], 0, "second crossing stall");
      for (int i = 1; i < k1 + 18; i++) begin
         if (i != k1) check(gaps[i] == 0, "R3", gaps[i], 0, "gap between words");
      end
   endtask

   initial begin
      int hits;
      repeat (4) @(negedge clk);
      check(ready == 1'b0, "R7", int'(ready), 0, "reset ready");
      check(data_out == '0, "R7", int'(data_out), 0, "reset data");
      rst_n = 1'b1;

      // R1: strobe with chip enable low
      cur_tag = "R1";
      @(negedge clk);
      addr_strobe = 1'b1; addr_in = 24'h5;
      hits = 0;
      for (int i = 0; i < 10; i++) begin
         @(negedge clk);
         if (ready) hits++;
      end
      addr_strobe = 1'b0;
      check(hits == 0, "R1", hits, 0, "ready clocks with chip enable low");

      crossing_case(32'h23, "R4");
      crossing_case(32'h41, "R4");
      crossing_case(32'h16, "R4");
      crossing_case(32'h20, "R4");  // multiple of 16: zero stall
      crossing_case(32'h2F, "R6");  // crossing right after first word
      crossing_case(32'hFFFFFD, "R10");

      // R9: restart mid-burst while streaming
      cur_tag = "R9";
      burst(32'h2D, 8);
      crossing_case(32'h13, "R9");

      // R8: chip enable drop ends the burst at once
      cur_tag = "R8";
      burst(32'h33, 4);
      chip_en = 1'b0;
      @(negedge clk);
      check(ready == 1'b0, "R8", int'(ready), 0, "ready after chip enable drop");
      chip_en = 1'b1;
      hits = 0;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         if (ready) hits++;
      end
      check(hits == 0, "R8", hits, 0, "ready clocks without new strobe");

      // R2 again after an idle period
      crossing_case(32'h3A, "R2");

      chip_en = 1'b0;
      repeat (3) @(negedge clk);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 100000, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule